// File: doc/BRIEF.md
# Regulator Power-Up and Power-Down Sequencer

This block is the digital sequencer for a switching regulator. Once the supply-good flag is high, it runs a fixed initialization period and then captures the board strap code into a configuration register. That register holds until the supply drops. After initialization, a high enable starts a power-on delay. A soft-start ramp then drives a digital reference code from zero to full scale. The ramp length is taken from the captured configuration.

During soft start, the high-side driver stays off until the rising reference exceeds the digitized feedback value. This lets a pre-charged output start without being pulled down. The low-side driver is held off until the modulator reports its first high-side pulse. When the output is in regulation, a timer runs, and power-good asserts when that timer expires.

Dropping enable turns both drivers off in the same cycle and returns the reference to zero. All timing is counted in ticks of a divided clock.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After supply_ok_i rises, cfg_valid_o rises exactly INIT_TICKS ticks later (one tick is TICK_DIV clocks), whatever the level of en_i.
- R2: The configuration outputs are captured only at the end of initialization and stay constant while supply_ok_i is high; toggling en_i or changing strap_i never changes them.
- R3: Strap encoding: when strap_i[4] is 1 (floating), the configuration is soft-start select 2, compensation 0 and latch-off. Otherwise ss_sel_o = strap_i[1:0], comp_sel_o = strap_i[2] and hiccup_o = strap_i[3].
- R4: With the configuration valid and en_i high, the block waits PON_TICKS ticks with both drivers off and ref_o at 0, then starts the ramp.
- R5: k ticks into the ramp, ref_o equals floor(k*REF_FS/S), where S = SS_BASE_TICKS shifted left by ss_sel_o. ref_o reaches REF_FS exactly at k = S and holds there.
- R6: hs_en_o asserts only after ref_o has exceeded fb_i during ramp or regulation, and stays asserted until shutdown.
- R7: ls_en_o stays low until hs_pulse_i has been seen high while hs_en_o was high; ls_en_o is never high without hs_en_o.
- R8: pgood_o asserts once in_reg_i has been high during ramp or regulation for PG_TICKS consecutive ticks. It drops the cycle after in_reg_i falls.
- R9: When en_i is low, hs_en_o and ls_en_o are low in that same cycle. From the next cycle, ref_o and pgood_o are 0 and the power-on delay restarts on the next high enable.
- R10: A low supply_ok_i clears cfg_valid_o, the configuration outputs, pgood_o and ref_o on the next cycle, and a new initialization follows when it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Bias supply above its good threshold |
| en_i | input | 1 | Converter enable |
| strap_i | input | 5 | Digitized strap code, bit 4 meaning floating |
| fb_i | input | REF_W | Digitized feedback value on the reference scale |
| in_reg_i | input | 1 | Output is within its regulation window |
| hs_pulse_i | input | 1 | Modulator is issuing a high-side pulse |
| ref_o | output | REF_W | Soft-start reference code |
| hs_en_o | output | 1 | High-side driver enable |
| ls_en_o | output | 1 | Low-side driver enable |
| pgood_o | output | 1 | Power good |
| cfg_valid_o | output | 1 | Captured configuration is valid |
| ss_sel_o | output | 2 | Captured soft-start length select |
| comp_sel_o | output | 1 | Captured compensation select |
| hiccup_o | output | 1 | Captured fault response, 1 meaning hiccup |

## Verification
Two events can fall in the same cycle: the power-good timer expiring, and enable falling. The bench uses its own model to find the cycle where the last good tick lands, and drops enable just before that clock edge. It then expects the shutdown to win, so power-good never rises and the drivers and reference clear. A second collision comes from toggling enable and changing the strap inputs while the configuration is held. Here the bench expects the configuration outputs to stay unchanged.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_INIT = 3'd1,
        ST_IDLE = 3'd2,
        ST_PON  = 3'd3,
        ST_RAMP = 3'd4,
        ST_RUN  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [1:0] ss_sel;
        logic       comp_sel;
        logic       hiccup;
    } strap_cfg_t;

endpackage

// File: rtl/pwr_seq_tick.sv
module pwr_seq_tick #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(DIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwr_seq_strap.sv
module pwr_seq_strap
    import pwr_seq_pkg::*;
(
    input  logic [4:0]  code_i,
    output strap_cfg_t  cfg_o
);
    always_comb begin
        if (code_i[4]) begin
            cfg_o.ss_sel   = 2'd2;
            cfg_o.comp_sel = 1'b0;
            cfg_o.hiccup   = 1'b0;
        end else begin
            cfg_o.ss_sel   = code_i[1:0];
            cfg_o.comp_sel = code_i[2];
            cfg_o.hiccup   = code_i[3];
        end
    end
endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
    parameter int unsigned REF_W   = 10,
    parameter int unsigned REF_FS  = 1023,
    parameter int unsigned BASE    = 750,
    parameter int unsigned ACC_W   = 13
) (
    input  logic [1:0]       sel_i,
    input  logic [REF_W-1:0] ref_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [REF_W-1:0] ref_nx_o,
    output logic [ACC_W-1:0] acc_nx_o,
    output logic [ACC_W-1:0] span_o
);
    logic [REF_W-1:0] step_w [4];
    logic [ACC_W-1:0] rem_w  [4];
    logic [ACC_W-1:0] span_w [4];

    // Whole step and remainder per ramp length; remainder spread Bresenham style
    for (genvar g = 0; g < 4; g++) begin : g_opt
        localparam int unsigned SPAN = BASE << g;
        assign step_w[g] = REF_W'(REF_FS / SPAN);
        assign rem_w[g]  = ACC_W'(REF_FS % SPAN);
        assign span_w[g] = ACC_W'(SPAN);
    end

    logic [ACC_W:0] sum;
    logic           carry;

    always_comb begin
        span_o = span_w[sel_i];
        sum    = {1'b0, acc_i} + {1'b0, rem_w[sel_i]};
        carry  = (sum >= {1'b0, span_w[sel_i]});
        if (carry) acc_nx_o = ACC_W'(sum - {1'b0, span_w[sel_i]});
        else       acc_nx_o = ACC_W'(sum);
        ref_nx_o = ref_i + step_w[sel_i] + REF_W'(carry);
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 200,
    parameter int unsigned INIT_TICKS    = 300,
    parameter int unsigned PON_TICKS     = 500,
    parameter int unsigned PG_TICKS      = 1000,
    parameter int unsigned SS_BASE_TICKS = 750,
    parameter int unsigned REF_W         = 10,
    parameter int unsigned REF_FS        = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok_i,
    input  logic             en_i,
    input  logic [4:0]       strap_i,
    input  logic [REF_W-1:0] fb_i,
    input  logic             in_reg_i,
    input  logic             hs_pulse_i,
    output logic [REF_W-1:0] ref_o,
    output logic             hs_en_o,
    output logic             ls_en_o,
    output logic             pgood_o,
    output logic             cfg_valid_o,
    output logic [1:0]       ss_sel_o,
    output logic             comp_sel_o,
    output logic             hiccup_o
);
    localparam int unsigned SPAN_MAX = SS_BASE_TICKS * 8;
    localparam int unsigned T_A      = (INIT_TICKS > PON_TICKS) ? INIT_TICKS : PON_TICKS;
    localparam int unsigned TMR_MAX  = (T_A > SPAN_MAX) ? T_A : SPAN_MAX;
    localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);
    localparam int unsigned ACC_W    = $clog2(SPAN_MAX + 1);
    localparam int unsigned PG_W     = $clog2(PG_TICKS + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [TMR_W-1:0] tmr;
        logic [REF_W-1:0] ref_c;
        logic [ACC_W-1:0] acc;
        logic             started;
        logic             pulsed;
        logic [PG_W-1:0]  pgc;
        logic             pg;
        logic             cfg_v;
        strap_cfg_t       cfg;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_OFF, default: '0};

    ctl_t q, d;

    logic             tick;
    strap_cfg_t       dec_cfg;
    logic [REF_W-1:0] ref_nx;
    logic [ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0] span;
    logic             active;
    logic             hs_act;

    pwr_seq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pwr_seq_strap u_strap (
        .code_i (strap_i),
        .cfg_o  (dec_cfg)
    );

    pwr_seq_ramp #(
        .REF_W  (REF_W),
        .REF_FS (REF_FS),
        .BASE   (SS_BASE_TICKS),
        .ACC_W  (ACC_W)
    ) u_ramp (
        .sel_i    (q.cfg.ss_sel),
        .ref_i    (q.ref_c),
        .acc_i    (q.acc),
        .ref_nx_o (ref_nx),
        .acc_nx_o (acc_nx),
        .span_o   (span)
    );

    always_comb begin
        d      = q;
        active = (q.st == ST_RAMP) || (q.st == ST_RUN);
        hs_act = q.started & en_i & supply_ok_i;

        // Switching state: gate on reference above feedback, low side after first high pulse
        if (active) begin
            d.started = q.started | (q.ref_c > fb_i);
            d.pulsed  = q.pulsed | (hs_pulse_i & hs_act);
        end

        // Power-good timer
        if (active && in_reg_i) begin
            if (tick && !q.pg) begin
                if (q.pgc == PG_W'(PG_TICKS - 1)) d.pg  = 1'b1;
                else                              d.pgc = q.pgc + PG_W'(1);
            end
        end else begin
            d.pgc = '0;
            d.pg  = 1'b0;
        end

        unique case (q.st)
            ST_OFF: begin
                if (supply_ok_i) begin
                    d.st  = ST_INIT;
                    d.tmr = '0;
                end
            end
            ST_INIT: begin
                if (tick) begin
                    if (q.tmr == TMR_W'(INIT_TICKS - 1)) begin
                        d.st    = ST_IDLE;
                        d.tmr   = '0;
                        d.cfg   = dec_cfg;
                        d.cfg_v = 1'b1;
                    end else begin
                        d.tmr = q.tmr + TMR_W'(1);
                    end
                end
            end
            ST_IDLE: begin
                if (en_i) begin
                    d.st  = ST_PON;
                    d.tmr = '0;
                end
            end
            ST_PON: begin
                if (tick) begin
                    if (q.tmr == TMR_W'(PON_TICKS - 1)) begin
                        d.st    = ST_RAMP;
                        d.tmr   = '0;
                        d.ref_c = '0;
                        d.acc   = '0;
                    end else begin
                        d.tmr = q.tmr + TMR_W'(1);
                    end
                end
            end
            ST_RAMP: begin
                if (tick) begin
                    d.ref_c = ref_nx;
                    d.acc   = acc_nx;
                    if (q.tmr == TMR_W'(span - ACC_W'(1))) begin
                        d.st  = ST_RUN;
                        d.tmr = '0;
                    end else begin
                        d.tmr = q.tmr + TMR_W'(1);
                    end
                end
            end
            default: ;
        endcase

        // Enable low: immediate shutdown, reference discharged
        if ((q.st == ST_PON || active) && !en_i) begin
            d.st      = ST_IDLE;
            d.tmr     = '0;
            d.ref_c   = '0;
            d.acc     = '0;
            d.started = 1'b0;
            d.pulsed  = 1'b0;
            d.pgc     = '0;
            d.pg      = 1'b0;
        end

        // Supply loss overrides everything
        if (!supply_ok_i) d = CTL_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign ref_o       = q.ref_c;
    assign hs_en_o     = hs_act;
    assign ls_en_o     = hs_act & q.pulsed;
    assign pgood_o     = q.pg;
    assign cfg_valid_o = q.cfg_v;
    assign ss_sel_o    = q.cfg.ss_sel;
    assign comp_sel_o  = q.cfg.comp_sel;
    assign hiccup_o    = q.cfg.hiccup;

    // Captured configuration never moves while valid
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && $past(cfg_valid_o)) |-> $stable({ss_sel_o, comp_sel_o, hiccup_o}));

    // Reference only climbs, except when it is discharged to zero
    p_ref_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_o != $past(ref_o)) |-> ((ref_o > $past(ref_o)) || (ref_o == '0)));

    p_ref_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_o <= REF_W'(REF_FS));

    p_ls_needs_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en_o |-> hs_en_o);

    p_pg_inreg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> ($past(in_reg_i) && $past(en_i)));

    p_shutdown_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (ref_o == '0));

    p_supply_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (!cfg_valid_o && !pgood_o && (ref_o == '0)));
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
    localparam int DIV_T  = 3;
    localparam int INIT_T = 20;
    localparam int PON_T  = 15;
    localparam int PG_T   = 25;
    localparam int BASE_T = 10;
    localparam int FS     = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sup = 1'b0;
    logic       en = 1'b0;
    logic [4:0] strap = 5'd0;
    logic [9:0] fb = 10'd0;
    logic       in_reg = 1'b0;
    logic       hs_pulse = 1'b0;

    logic [9:0] ref_o;
    logic       hs_en, ls_en, pgood, cfg_valid, comp_sel, hiccup;
    logic [1:0] ss_sel;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(
        .TICK_DIV(DIV_T), .INIT_TICKS(INIT_T), .PON_TICKS(PON_T),
        .PG_TICKS(PG_T), .SS_BASE_TICKS(BASE_T), .REF_W(10), .REF_FS(FS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(sup), .en_i(en), .strap_i(strap),
        .fb_i(fb), .in_reg_i(in_reg), .hs_pulse_i(hs_pulse),
        .ref_o(ref_o), .hs_en_o(hs_en), .ls_en_o(ls_en), .pgood_o(pgood),
        .cfg_valid_o(cfg_valid), .ss_sel_o(ss_sel), .comp_sel_o(comp_sel), .hiccup_o(hiccup)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // Behavioural reference: phases 0 off,1 init,2 wait,3 delay,4 ramp,5 regulate
    int m_div, m_ph, m_kk, m_ref, m_pgc, m_ss, m_comp, m_hic;
    bit m_started, m_pulsed, m_pg, m_cv;

    task automatic m_clear_all();
        m_ph = 0; m_kk = 0; m_ref = 0; m_pgc = 0; m_pg = 0;
        m_started = 0; m_pulsed = 0; m_cv = 0; m_ss = 0; m_comp = 0; m_hic = 0;
    endtask

    initial begin
        m_div = 0;
        m_clear_all();
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0;
            m_clear_all();
        end else begin : mdl
            bit tk, hs_now, act;
            int ph0, span;
            tk = (m_div == DIV_T - 1);
            m_div = tk ? 0 : m_div + 1;
            ph0 = m_ph;
            hs_now = m_started && en && sup;
            act = (ph0 == 4) || (ph0 == 5);
            span = BASE_T << m_ss;
            if (act) begin
                if (m_ref > int'(fb)) m_started = 1;
                if (hs_pulse && hs_now) m_pulsed = 1;
            end
            if (act && in_reg) begin
                if (tk && !m_pg) begin
                    m_pgc++;
                    if (m_pgc == PG_T) m_pg = 1;
                end
            end else begin
                m_pgc = 0; m_pg = 0;
            end
            case (ph0)
                0: if (sup) begin m_ph = 1; m_kk = 0; end
                1: if (tk) begin
                       m_kk++;
                       if (m_kk == INIT_T) begin
                           m_ph = 2; m_kk = 0; m_cv = 1;
                           if (strap[4]) begin m_ss = 2; m_comp = 0; m_hic = 0; end
                           else begin m_ss = strap[1:0]; m_comp = strap[2]; m_hic = strap[3]; end
                       end
                   end
                2: if (en) begin m_ph = 3; m_kk = 0; end
                3: if (tk) begin
                       m_kk++;
                       if (m_kk == PON_T) begin m_ph = 4; m_kk = 0; m_ref = 0; end
                   end
                4: if (tk) begin
                       m_kk++;
                       m_ref = (m_kk * FS) / span;
                       if (m_kk == span) begin m_ph = 5; m_kk = 0; end
                   end
                default: ;
            endcase
            if (ph0 >= 3 && !en) begin
                m_ph = 2; m_kk = 0; m_ref = 0; m_started = 0; m_pulsed = 0; m_pgc = 0; m_pg = 0;
            end
            if (!sup) m_clear_all();
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R1 cfg_valid", cfg_valid, m_cv);
            chk("R3 ss_sel", ss_sel, m_ss);
            chk("R3 comp_sel", comp_sel, m_comp);
            chk("R3 hiccup", hiccup, m_hic);
            chk("R5 ref", ref_o, m_ref);
            chk("R6 hs_en", hs_en, m_started && en && sup);
            chk("R7 ls_en", ls_en, m_started && en && sup && m_pulsed);
            chk("R8 pgood", pgood, m_pg);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin : stim
        int c0;
        step(5);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(2);
        chk("R1 reset cfg_valid", cfg_valid, 0);
        chk("R5 reset ref", ref_o, 0);

        // R1: enable already high during initialization
        strap = 5'd6; en = 1'b1; sup = 1'b1;
        step(1);
        c0 = 0;
        while (!cfg_valid && c0 < 500) begin step(1); c0++; end
        chk("R1 init length window", (c0 >= INIT_T*DIV_T - DIV_T) && (c0 <= INIT_T*DIV_T + 1), 1);
        // R4: power-on delay keeps reference low and drivers off
        step(PON_T*DIV_T/2);
        chk("R4 delay ref", ref_o, 0);
        chk("R4 delay hs", hs_en, 0);
        step(PON_T*DIV_T/2 + 60);
        hs_pulse = 1'b1; step(1); hs_pulse = 1'b0;
        step(100);
        chk("R5 full scale", ref_o, FS);
        chk("R7 ls after pulse", ls_en, 1);
        in_reg = 1'b1; step(100);
        chk("R8 pgood up", pgood, 1);
        in_reg = 1'b0; step(3); in_reg = 1'b1; step(90);

        // R2: enable toggle and strap change must not re-capture
        strap = 5'd0; en = 1'b0;
        #0.5 chk("R9 hs same cycle", hs_en, 0);
        chk("R9 ls same cycle", ls_en, 0);
        step(1);
        chk("R9 ref cleared", ref_o, 0);
        step(10);
        en = 1'b1; fb = 10'd600;
        step(5);
        chk("R2 ss held", ss_sel, 2);
        chk("R2 comp held", comp_sel, 1);

        // Collision: enable falls on the edge where power-good would rise
        c0 = 0;
        while (!((m_ph == 4 || m_ph == 5) && m_pgc == PG_T - 1 && m_div == DIV_T - 1 && !m_pg)
               && c0 < 2000) begin
            @(negedge clk); c0++;
        end
        #1 en = 1'b0;
        step(1);
        chk("R9 pgood blocked by shutdown", pgood, 0);
        chk("R9 ref after collision", ref_o, 0);
        step(5);

        // R10: supply loss clears configuration; floating strap on re-init
        sup = 1'b0; step(1);
        chk("R10 cfg cleared", cfg_valid, 0);
        strap = 5'b10000; step(4);
        sup = 1'b1; step(INIT_T*DIV_T + 10);
        chk("R3 floating ss", ss_sel, 2);
        chk("R3 floating hiccup", hiccup, 0);

        // Longest ramp with prebias start from zero feedback
        sup = 1'b0; strap = 5'd3; fb = 10'd0; step(3);
        sup = 1'b1; en = 1'b1; step(INIT_T*DIV_T + PON_T*DIV_T + 80*DIV_T + 20);
        chk("R5 longest ramp end", ref_o, FS);

        // Shortest ramp, hiccup strap, supply drop mid-ramp
        sup = 1'b0; strap = 5'd8; step(3);
        sup = 1'b1; step(INIT_T*DIV_T + PON_T*DIV_T + 15);
        sup = 1'b0; step(1);
        chk("R10 ref cleared", ref_o, 0);
        sup = 1'b1; step(INIT_T*DIV_T + PON_T*DIV_T + 10*DIV_T + 20);
        chk("R5 shortest ramp end", ref_o, FS);
        chk("R3 hiccup strap", hiccup, 1);
        step(5);
        finish_run();
    end
endmodule